// File: doc/BRIEF.md
# Table Pointer Memory Access Engine

This block carries out already-decoded table commands against a 22-bit byte address space. It owns a byte pointer, a one-byte read latch and a small write holding buffer. Read commands fetch one byte into the latch and adjust the pointer in one of four ways. Write commands put 2-byte payloads into the buffer. The program commands then write the buffer out to memory. A row erase fills a 64-byte aligned row with ones.

Addresses are split into regions. Code space is 8 KiB or 16 KiB, chosen by a size input. Above it, up to the top of the lower half of the space, nothing is implemented and reads return zero. There is a small ID window, a block of configuration bytes, and two fixed identification bytes at the very top of the space. The storage array is outside the block, behind a one-byte request/acknowledge port. Program and erase are followed by a fixed busy period, and commands are refused while it lasts.

Top module: `tbl_access_engine`

## Requirements
- R1: After reset the pointer and the latch are 0, cmdReady is 1, busy is 0 and memReq is 0.
- R2: Opcode 1 loads the pointer from cmdAddr. The latch changes only on read commands (opcodes 2 to 5).
- R3: Opcode 2 reads at the pointer and leaves it unchanged. Opcode 3 reads and then adds 1. Opcode 4 reads and then subtracts 1. Opcode 5 adds 1 first and then reads at the new pointer. The byte read goes to tableLatch.
- R4: Code space ends at 0x2000 when bigCode is 0 and at 0x4000 when bigCode is 1. A read from an address that maps to nothing returns 0 and makes no memory request.
- R5: Addresses 0x200000–0x200007 (ID) and 0x300000–0x30000D (configuration) are served through the memory port. A read of 0x3FFFFE returns DEVID_LO (default 0x4C) and a read of 0x3FFFFF returns DEVID_HI (default 0xA7), both without a memory request.
- R6: Incrementing a pointer below 0x200000 never sets bit 21, so 0x1FFFFF + 1 gives 0x000000. At or above 0x200000 the pointer wraps modulo 2^22, and 0x000000 − 1 gives 0x3FFFFF.
- R7: Opcode 6 stores cmdData[7:0] in the even slot and cmdData[15:8] in the odd slot of the buffer pair that the pointer selects (buffer index = pointer mod BUF_BYTES, default 16). Opcode 7 does the same and then adds 2 to the pointer.
- R8: Outside the configuration region, opcode 9 (and opcode 8, which also adds 2 to the pointer afterwards) first stores its payload as in R7. It then writes all BUF_BYTES buffer bytes, in ascending order, to the BUF_BYTES-aligned block that holds the pointer, skipping addresses that map to nothing. After that every buffer byte is set to 0xFF.
- R9: When the pointer is in the configuration region, a program command writes exactly one byte at the pointer: cmdData[7:0] if the pointer is even, cmdData[15:8] if it is odd.
- R10: Opcode 10 writes 0xFF to every mapped byte of the 64-byte aligned row that holds the pointer. It leaves the pointer unchanged and writes nothing outside the row.
- R11: After the memory writes of a program or erase, busy stays high for BUSY_CYCLES more cycles. cmdReady is 0 while busy is high, and commands presented then are ignored.
- R12: memReq stays high, with memAddr, memWe and memWdata stable, until memAck. Each handshake moves one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bigCode | input | 1 | Code size select: 0 = 8 KiB, 1 = 16 KiB |
| cmdValid | input | 1 | Command present |
| cmdOp | input | 4 | Opcode (see requirements) |
| cmdData | input | 16 | Write payload |
| cmdAddr | input | 22 | Pointer value for the load command |
| cmdReady | output | 1 | Engine idle; a command is taken on this cycle |
| busy | output | 1 | Program/erase in progress |
| tablePtr | output | 22 | Current pointer |
| tableLatch | output | 8 | Last byte read |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Request is a write |
| memAddr | output | 22 | Memory byte address |
| memWdata | output | 8 | Write byte |
| memAck | input | 1 | Request completed |
| memRdata | input | 8 | Read byte, valid with memAck |

## Verification
The hardest cases to reach from the ports are the pointer boundaries and commands that arrive during the busy period. For the boundaries, the bench loads the pointer directly at 0x1FFFFF, 0x3FFFFE and 0x000000, then reads with each increment and decrement form and checks both where the pointer lands and what the latch returns. For the busy case, the bench presents a pointer load throughout an erase and confirms afterwards that the pointer did not move. The memory model counts reads and writes. Those counts show that unmapped reads make no request, that a configuration program writes only one byte, and that an erase in unimplemented space writes nothing.

// File: rtl/tae_pkg.sv
package tae_pkg;

  typedef enum logic [3:0] {
    OP_NOP          = 4'd0,
    OP_LOAD         = 4'd1,
    OP_RD           = 4'd2,
    OP_RD_POSTINC   = 4'd3,
    OP_RD_POSTDEC   = 4'd4,
    OP_RD_PREINC    = 4'd5,
    OP_WR           = 4'd6,
    OP_WR_INC2      = 4'd7,
    OP_WR_PROG_INC2 = 4'd8,
    OP_WR_PROG      = 4'd9,
    OP_ERASE        = 4'd10
  } tae_op_e;

  typedef enum logic [1:0] {
    SW_PROG  = 2'd0,
    SW_CFG   = 2'd1,
    SW_ERASE = 2'd2
  } sweep_kind_e;

  typedef struct packed {
    logic        ptrLoad;
    logic        ptrInc1;
    logic        ptrDec1;
    logic        ptrInc2;
    logic        latchCap;
    logic        bufWrite;
    logic        bufClear;
    logic        sweepStart;
    sweep_kind_e sweepKind;
    logic        sweepStep;
    logic        useSweep;
  } tae_strobe_t;

endpackage

// File: rtl/tae_region.sv
module tae_region #(
  parameter int ADDR_W     = 22,
  parameter int CODE_SMALL = 'h2000,
  parameter int CODE_LARGE = 'h4000,
  parameter int ID_BASE    = 'h200000,
  parameter int ID_BYTES   = 8,
  parameter int CFG_BASE   = 'h300000,
  parameter int CFG_BYTES  = 14,
  parameter logic [7:0] DEVID_LO = 8'h4C,
  parameter logic [7:0] DEVID_HI = 8'hA7
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              bigCode,
  output logic              mapped,
  output logic              inCfg,
  output logic [7:0]        constByte
);
  localparam logic [ADDR_W-1:0] codeSmallLim = ADDR_W'(CODE_SMALL);
  localparam logic [ADDR_W-1:0] codeLargeLim = ADDR_W'(CODE_LARGE);
  localparam logic [ADDR_W-1:0] idLo  = ADDR_W'(ID_BASE);
  localparam logic [ADDR_W-1:0] idHi  = ADDR_W'(ID_BASE + ID_BYTES);
  localparam logic [ADDR_W-1:0] cfgLo = ADDR_W'(CFG_BASE);
  localparam logic [ADDR_W-1:0] cfgHi = ADDR_W'(CFG_BASE + CFG_BYTES);
  localparam logic [ADDR_W-1:0] devTop = {ADDR_W{1'b1}};

  logic inCode, inId;

  always_comb begin
    inCode    = addr < (bigCode ? codeLargeLim : codeSmallLim);
    inId      = (addr >= idLo) && (addr < idHi);
    inCfg     = (addr >= cfgLo) && (addr < cfgHi);
    mapped    = inCode || inId || inCfg;
    constByte = 8'h00;
    if (addr == devTop)               constByte = DEVID_HI;
    else if (addr == devTop - 1'b1)   constByte = DEVID_LO;
  end
endmodule

// File: rtl/tae_datapath.sv
module tae_datapath
  import tae_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int BUF_BYTES = 16,
  parameter int ROW_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bigCode,
  input  tae_strobe_t       stb,
  input  logic [15:0]       cmdData,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [7:0]        memRdata,
  output logic [ADDR_W-1:0] tablePtr,
  output logic [7:0]        tableLatch,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic              ptrMapped,
  output logic              ptrInCfg,
  output logic              sweepMapped,
  output logic              sweepLast
);
  localparam int IDX_W = $clog2(BUF_BYTES);
  localparam int SPAN  = (ROW_BYTES > BUF_BYTES) ? ROW_BYTES : BUF_BYTES;
  localparam int CNT_W = $clog2(SPAN);

  logic [ADDR_W-1:0] ptr, sweepAddr;
  logic [CNT_W-1:0]  sweepCnt;
  logic [7:0]        bufMem [BUF_BYTES];
  logic [7:0]        latchQ, ptrConst, sweepConst;
  sweep_kind_e       kind;
  logic              sweepInCfg;
  logic [IDX_W-1:0]  pairIdx;

  // Increment that never carries out of the lower half into the upper half
  function automatic logic [ADDR_W-1:0] advance(input logic [ADDR_W-1:0] p,
                                                input logic [1:0] stepBy);
    logic [ADDR_W-1:0] n;
    n = p + ADDR_W'(stepBy);
    if (!p[ADDR_W-1]) n[ADDR_W-1] = 1'b0;
    return n;
  endfunction

  tae_region #(.ADDR_W(ADDR_W)) u_ptrRegion (
    .addr(ptr), .bigCode(bigCode), .mapped(ptrMapped),
    .inCfg(ptrInCfg), .constByte(ptrConst));

  tae_region #(.ADDR_W(ADDR_W)) u_sweepRegion (
    .addr(sweepAddr), .bigCode(bigCode), .mapped(sweepMapped),
    .inCfg(sweepInCfg), .constByte(sweepConst));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               ptr <= '0;
    else if (stb.ptrLoad)    ptr <= cmdAddr;
    else if (stb.ptrInc1)    ptr <= advance(ptr, 2'd1);
    else if (stb.ptrDec1)    ptr <= ptr - 1'b1;
    else if (stb.ptrInc2)    ptr <= advance(ptr, 2'd2);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             latchQ <= 8'h00;
    else if (stb.latchCap) latchQ <= ptrMapped ? memRdata : ptrConst;
  end

  assign pairIdx = {ptr[IDX_W-1:1], 1'b0};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BUF_BYTES; i++) bufMem[i] <= 8'hFF;
    end else if (stb.bufClear) begin
      for (int i = 0; i < BUF_BYTES; i++) bufMem[i] <= 8'hFF;
    end else if (stb.bufWrite) begin
      bufMem[pairIdx]        <= cmdData[7:0];
      bufMem[pairIdx | 1'b1] <= cmdData[15:8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sweepAddr <= '0;
      sweepCnt  <= '0;
      kind      <= SW_PROG;
    end else if (stb.sweepStart) begin
      kind <= stb.sweepKind;
      unique case (stb.sweepKind)
        SW_ERASE: begin
          sweepAddr <= ptr & ~ADDR_W'(ROW_BYTES - 1);
          sweepCnt  <= CNT_W'(ROW_BYTES - 1);
        end
        SW_CFG: begin
          sweepAddr <= ptr;
          sweepCnt  <= '0;
        end
        default: begin
          sweepAddr <= ptr & ~ADDR_W'(BUF_BYTES - 1);
          sweepCnt  <= CNT_W'(BUF_BYTES - 1);
        end
      endcase
    end else if (stb.sweepStep) begin
      sweepAddr <= sweepAddr + 1'b1;
      sweepCnt  <= sweepCnt - 1'b1;
    end
  end

  assign sweepLast  = (sweepCnt == '0);
  assign memAddr    = stb.useSweep ? sweepAddr : ptr;
  assign memWdata   = (kind == SW_ERASE) ? 8'hFF : bufMem[sweepAddr[IDX_W-1:0]];
  assign tablePtr   = ptr;
  assign tableLatch = latchQ;

  // R6: an increment from the lower half stays in the lower half
  a_r6_no_carry_up: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ptrInc1 && !ptr[ADDR_W-1]) |=> !ptr[ADDR_W-1]);

  // R2: the latch moves only on a capture strobe
  a_r2_latch_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.latchCap |=> $stable(latchQ));

  // R9: a single-byte sweep targets the configuration region
  a_r9_cfg_sweep_region: assert property (@(posedge clk) disable iff (!rstN)
    (stb.useSweep && kind == SW_CFG) |-> sweepInCfg);

  // R5: bytes written through memory are never the fixed identification bytes
  a_r5_mapped_not_const: assert property (@(posedge clk) disable iff (!rstN)
    (stb.useSweep && sweepMapped) |-> (sweepConst == 8'h00));
endmodule

// File: rtl/tae_ctrl.sv
module tae_ctrl
  import tae_pkg::*;
#(
  parameter int BUSY_CYCLES = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  tae_op_e     cmdOp,
  input  logic        ptrMapped,
  input  logic        ptrInCfg,
  input  logic        sweepMapped,
  input  logic        sweepLast,
  input  logic        memAck,
  output logic        cmdReady,
  output logic        busy,
  output logic        memReq,
  output logic        memWe,
  output tae_strobe_t stb
);
  localparam int HOLD_W = $clog2(BUSY_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_RD_START, S_RD_MEM, S_SWEEP, S_HOLD} state_e;

  state_e            state, nextState;
  tae_op_e           rdOp;
  logic              eraseRun;
  logic [HOLD_W-1:0] holdCnt;
  logic              sweepDone;

  always_comb begin
    stb       = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    nextState = state;
    sweepDone = 1'b0;
    unique case (state)
      S_IDLE: if (cmdValid) begin
        unique case (cmdOp)
          OP_LOAD:       stb.ptrLoad = 1'b1;
          OP_RD, OP_RD_POSTINC, OP_RD_POSTDEC: nextState = S_RD_START;
          OP_RD_PREINC: begin
            stb.ptrInc1 = 1'b1;
            nextState   = S_RD_START;
          end
          OP_WR:         stb.bufWrite = 1'b1;
          OP_WR_INC2: begin
            stb.bufWrite = 1'b1;
            stb.ptrInc2  = 1'b1;
          end
          OP_WR_PROG, OP_WR_PROG_INC2: begin
            stb.bufWrite   = 1'b1;
            stb.sweepStart = 1'b1;
            stb.sweepKind  = ptrInCfg ? SW_CFG : SW_PROG;
            stb.ptrInc2    = (cmdOp == OP_WR_PROG_INC2);
            nextState      = S_SWEEP;
          end
          OP_ERASE: begin
            stb.sweepStart = 1'b1;
            stb.sweepKind  = SW_ERASE;
            nextState      = S_SWEEP;
          end
          default: ;
        endcase
      end
      S_RD_START, S_RD_MEM: begin
        if (state == S_RD_START && ptrMapped) begin
          nextState = S_RD_MEM;
        end else begin
          memReq = (state == S_RD_MEM);
          if (state == S_RD_START || memAck) begin
            stb.latchCap = 1'b1;
            stb.ptrInc1  = (rdOp == OP_RD_POSTINC);
            stb.ptrDec1  = (rdOp == OP_RD_POSTDEC);
            nextState    = S_IDLE;
          end
        end
      end
      S_SWEEP: begin
        stb.useSweep = 1'b1;
        memReq       = sweepMapped;
        memWe        = sweepMapped;
        sweepDone    = !sweepMapped || memAck;
        if (sweepDone) begin
          if (sweepLast) begin
            stb.bufClear = !eraseRun;
            nextState    = S_HOLD;
          end else begin
            stb.sweepStep = 1'b1;
          end
        end
      end
      S_HOLD: if (holdCnt == '0) nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      rdOp     <= OP_NOP;
      eraseRun <= 1'b0;
      holdCnt  <= '0;
    end else begin
      state <= nextState;
      if (state == S_IDLE && cmdValid) rdOp <= cmdOp;
      if (stb.sweepStart) eraseRun <= (stb.sweepKind == SW_ERASE);
      if (state == S_SWEEP && nextState == S_HOLD) holdCnt <= HOLD_W'(BUSY_CYCLES - 1);
      else if (state == S_HOLD && holdCnt != '0)   holdCnt <= holdCnt - 1'b1;
    end
  end

  assign cmdReady = (state == S_IDLE);
  assign busy     = (state == S_SWEEP) || (state == S_HOLD);

  // R11: nothing is accepted during program/erase
  a_r11_refuse_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !cmdReady);

  // R11: an accepted erase raises busy on the next cycle
  a_r11_busy_after_erase: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && cmdOp == OP_ERASE) |=> busy);

  // R12: a request is held until acknowledged
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq);
endmodule

// File: rtl/tbl_access_engine.sv
module tbl_access_engine
  import tae_pkg::*;
#(
  parameter int ADDR_W      = 22,
  parameter int BUF_BYTES   = 16,
  parameter int ROW_BYTES   = 64,
  parameter int BUSY_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bigCode,
  input  logic              cmdValid,
  input  logic [3:0]        cmdOp,
  input  logic [15:0]       cmdData,
  input  logic [ADDR_W-1:0] cmdAddr,
  output logic              cmdReady,
  output logic              busy,
  output logic [ADDR_W-1:0] tablePtr,
  output logic [7:0]        tableLatch,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  input  logic              memAck,
  input  logic [7:0]        memRdata
);
  tae_strobe_t stb;
  logic ptrMapped, ptrInCfg, sweepMapped, sweepLast;

  tae_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(tae_op_e'(cmdOp)),
    .ptrMapped(ptrMapped), .ptrInCfg(ptrInCfg), .sweepMapped(sweepMapped),
    .sweepLast(sweepLast), .memAck(memAck), .cmdReady(cmdReady), .busy(busy),
    .memReq(memReq), .memWe(memWe), .stb(stb));

  tae_datapath #(.ADDR_W(ADDR_W), .BUF_BYTES(BUF_BYTES), .ROW_BYTES(ROW_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .bigCode(bigCode), .stb(stb), .cmdData(cmdData),
    .cmdAddr(cmdAddr), .memRdata(memRdata), .tablePtr(tablePtr),
    .tableLatch(tableLatch), .memAddr(memAddr), .memWdata(memWdata),
    .ptrMapped(ptrMapped), .ptrInCfg(ptrInCfg), .sweepMapped(sweepMapped),
    .sweepLast(sweepLast));

  // R12: address and data stay put while a request waits
  a_r12_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> ($stable(memAddr) && $stable(memWdata) && $stable(memWe)));
endmodule

// File: tb/tbl_access_engine_bench.sv
module tbl_access_engine_bench;
  localparam int BUSY = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bigCode = 1'b1;
  logic        cmdValid = 1'b0;
  logic [3:0]  cmdOp = 4'd0;
  logic [15:0] cmdData = 16'h0;
  logic [21:0] cmdAddr = 22'h0;
  logic        cmdReady, busy, memReq, memWe;
  logic [21:0] tablePtr, memAddr;
  logic [7:0]  tableLatch, memWdata;
  logic        memAck = 1'b0;
  logic [7:0]  memRdata = 8'h00;

  int checks = 0, errors = 0, wrCount = 0, rdCount = 0, cycles = 0;
  bit finished = 0;
  logic [7:0] mem [int];

  always #10 clk = ~clk;

  tbl_access_engine #(.BUSY_CYCLES(BUSY)) u_tbl_access_engine (
    .clk(clk), .rstN(rstN), .bigCode(bigCode), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdData(cmdData), .cmdAddr(cmdAddr), .cmdReady(cmdReady), .busy(busy),
    .tablePtr(tablePtr), .tableLatch(tableLatch), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata));

  always @(posedge clk) begin
    if (!rstN) memAck <= 1'b0;
    else if (memReq && !memAck) begin
      memAck <= 1'b1;
      if (memWe) begin
        mem[int'(memAddr)] = memWdata;
        wrCount++;
      end else begin
        memRdata <= mem.exists(int'(memAddr)) ? mem[int'(memAddr)] : 8'hFF;
        rdCount++;
      end
    end else memAck <= 1'b0;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rdMem(input int a);
    return mem.exists(a) ? mem[a] : 8'hFF;
  endfunction

  task automatic issue(input logic [3:0] op, input logic [15:0] d, input logic [21:0] a);
    @(negedge clk);
    while (!cmdReady) @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdData = d; cmdAddr = a;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitIdle();
    while (!cmdReady) @(negedge clk);
  endtask

  task automatic doCmd(input logic [3:0] op, input logic [15:0] d, input logic [21:0] a);
    issue(op, d, a);
    waitIdle();
  endtask

  task automatic t_reset();
    chk("R1 ptr", tablePtr, 0);
    chk("R1 latch", tableLatch, 0);
    chk("R1 ready", cmdReady, 1);
    chk("R1 busy", busy, 0);
    chk("R1 memReq", memReq, 0);
  endtask

  task automatic t_reads();
    mem[32'h10] = 8'hA1; mem[32'h11] = 8'hB2; mem[32'h12] = 8'hD4;
    doCmd(4'd1, 0, 22'h10);
    chk("R2 load", tablePtr, 22'h10);
    chk("R2 latch untouched by load", tableLatch, 0);
    doCmd(4'd2, 0, 0);
    chk("R3 plain latch", tableLatch, 8'hA1); chk("R3 plain ptr", tablePtr, 22'h10);
    doCmd(4'd3, 0, 0);
    chk("R3 postinc latch", tableLatch, 8'hA1); chk("R3 postinc ptr", tablePtr, 22'h11);
    doCmd(4'd5, 0, 0);
    chk("R3 preinc latch", tableLatch, 8'hD4); chk("R3 preinc ptr", tablePtr, 22'h12);
    doCmd(4'd4, 0, 0);
    chk("R3 postdec latch", tableLatch, 8'hD4); chk("R3 postdec ptr", tablePtr, 22'h11);
    doCmd(4'd2, 0, 0);
    chk("R3 reread", tableLatch, 8'hB2);
  endtask

  task automatic t_regions();
    int r0;
    mem[32'h2000] = 8'h77;
    bigCode = 1'b0;
    doCmd(4'd1, 0, 22'h2000);
    r0 = rdCount;
    doCmd(4'd2, 0, 0);
    chk("R4 small unimpl latch", tableLatch, 0);
    chk("R4 no request", rdCount - r0, 0);
    bigCode = 1'b1;
    doCmd(4'd2, 0, 0);
    chk("R4 large code latch", tableLatch, 8'h77);
    mem[32'h200003] = 8'h5E;
    doCmd(4'd1, 0, 22'h200003);
    doCmd(4'd2, 0, 0);
    chk("R5 id read", tableLatch, 8'h5E);
    doCmd(4'd1, 0, 22'h3FFFFE);
    r0 = rdCount;
    doCmd(4'd3, 0, 0);
    chk("R5 devid lo", tableLatch, 8'h4C);
    chk("R5 devid ptr", tablePtr, 22'h3FFFFF);
    doCmd(4'd3, 0, 0);
    chk("R5 devid hi", tableLatch, 8'hA7);
    chk("R5 devid no request", rdCount - r0, 0);
    chk("R6 wrap 2^22", tablePtr, 22'h0);
  endtask

  task automatic t_boundary();
    mem[32'h0] = 8'h3C;
    doCmd(4'd1, 0, 22'h1FFFFF);
    doCmd(4'd3, 0, 0);
    chk("R6 postinc no carry", tablePtr, 22'h0);
    chk("R6 unimpl read zero", tableLatch, 0);
    doCmd(4'd1, 0, 22'h1FFFFF);
    doCmd(4'd5, 0, 0);
    chk("R6 preinc no carry", tablePtr, 22'h0);
    chk("R6 preinc reads new", tableLatch, 8'h3C);
    doCmd(4'd4, 0, 0);
    chk("R6 dec wrap", tablePtr, 22'h3FFFFF);
  endtask

  task automatic t_program();
    int w0;
    logic [7:0] exp [16];
    doCmd(4'd1, 0, 22'h10A);
    doCmd(4'd6, 16'h8877, 0);
    chk("R7 plain write ptr", tablePtr, 22'h10A);
    doCmd(4'd1, 0, 22'h104);
    doCmd(4'd7, 16'h2211, 0);
    chk("R7 inc2 ptr", tablePtr, 22'h106);
    doCmd(4'd7, 16'h4433, 0);
    w0 = wrCount;
    issue(4'd9, 16'h6655, 0);
    chk("R11 busy after program", busy, 1);
    chk("R11 not ready", cmdReady, 0);
    waitIdle();
    chk("R12 one write per byte", wrCount - w0, 16);
    chk("R8 ptr kept", tablePtr, 22'h108);
    chk("R2 latch untouched by writes", tableLatch, 8'h3C);
    foreach (exp[i]) exp[i] = 8'hFF;
    exp[4] = 8'h11; exp[5] = 8'h22; exp[6] = 8'h33; exp[7] = 8'h44;
    exp[8] = 8'h55; exp[9] = 8'h66; exp[10] = 8'h77; exp[11] = 8'h88;
    for (int i = 0; i < 16; i++) chk($sformatf("R8 block byte %0d", i), rdMem(32'h100 + i), exp[i]);
    doCmd(4'd1, 0, 22'h100);
    doCmd(4'd8, 16'hBBAA, 0);
    chk("R8 prog inc2 ptr", tablePtr, 22'h102);
    chk("R8 byte0", rdMem(32'h100), 8'hAA);
    chk("R8 byte1", rdMem(32'h101), 8'hBB);
    chk("R8 buffer cleared", rdMem(32'h104), 8'hFF);
  endtask

  task automatic t_config();
    int w0, busyN;
    mem[32'h300004] = 8'h11; mem[32'h300005] = 8'h22;
    doCmd(4'd1, 0, 22'h300005);
    w0 = wrCount; busyN = 0;
    issue(4'd9, 16'h9C3A, 0);
    while (!cmdReady) begin
      if (busy) busyN++;
      @(negedge clk);
    end
    chk("R9 odd byte", rdMem(32'h300005), 8'h9C);
    chk("R9 neighbour kept", rdMem(32'h300004), 8'h11);
    chk("R9 single write", wrCount - w0, 1);
    chk("R11 busy length", busyN, BUSY + 2);
    doCmd(4'd1, 0, 22'h300004);
    doCmd(4'd9, 16'h5F6E, 0);
    chk("R9 even byte", rdMem(32'h300004), 8'h6E);
    chk("R9 odd kept", rdMem(32'h300005), 8'h9C);
  endtask

  task automatic t_erase();
    int w0;
    bit allOnes;
    for (int i = 32'h1C0; i < 32'h200; i++) mem[i] = 8'h00;
    mem[32'h1BF] = 8'h34; mem[32'h200] = 8'h12;
    doCmd(4'd1, 0, 22'h1E7);
    w0 = wrCount;
    issue(4'd10, 0, 0);
    // commands presented while busy must be ignored
    while (busy) begin
      cmdValid = 1'b1; cmdOp = 4'd1; cmdAddr = 22'h123;
      @(negedge clk);
    end
    cmdValid = 1'b0;
    waitIdle();
    chk("R11 load refused while busy", tablePtr, 22'h1E7);
    chk("R10 ptr unchanged", tablePtr, 22'h1E7);
    chk("R10 row writes", wrCount - w0, 64);
    allOnes = 1;
    for (int i = 32'h1C0; i < 32'h200; i++) if (rdMem(i) != 8'hFF) allOnes = 0;
    chk("R10 row all ones", allOnes, 1);
    chk("R10 below row kept", rdMem(32'h1BF), 8'h34);
    chk("R10 above row kept", rdMem(32'h200), 8'h12);
    bigCode = 1'b0;
    mem[32'h2040] = 8'h00;
    doCmd(4'd1, 0, 22'h2040);
    w0 = wrCount;
    doCmd(4'd10, 0, 0);
    chk("R10 unmapped row no writes", wrCount - w0, 0);
    chk("R10 unmapped byte kept", rdMem(32'h2040), 8'h00);
    bigCode = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_reads();
    t_regions();
    t_boundary();
    t_program();
    t_config();
    t_erase();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule